// File: doc/BRIEF.md
# Phase-Clocked Majority-Logic Adder

This block adds two unsigned operands and a carry-in using nothing but clocked gate cells: AND, OR, three-input majority and buffer/splitter. Every cell evaluates its Boolean function and holds the result in a storage element. The cell writes that element only while its assigned excitation phase is enabled. Three phase enables rotate, and gate level k listens to phase k mod 3. One operand wave therefore moves one gate level forward per enabled phase. Inverting any cell input costs nothing, so each cell instance carries a per-input invert mask. NOT is a buffer with its input inverted.

The datapath works as follows. One level forms a generate bit (AND) and a transmit bit (OR) per position, with the carry-in joined as an extra lowest position. A log-depth parallel-prefix carry lookahead follows. Each prefix combine needs only two majority cells: group generate = MAJ(g_hi, t_hi, g_lo) and group transmit = MAJ(g_hi, t_hi, t_lo). These hold because a group's generate never exceeds its transmit. The half-sum bits pass through buffer rows so that every cell draws its inputs from the level just before it. Two more levels form XOR with the incoming carry. A valid bit passes through a buffer at every level alongside the data. After reset, every stored level reads as logic 0 (negative output current) with valid low, so a value that was never driven is never reported as valid.

With the default width of 16 there are 9 levels (L0..L8). The operand pair is captured at L0 on a phase-0 edge, and the result appears 8 enabled edges later on a phase-2 edge. A new operand pair can enter on every phase-0 edge, which is once per full rotation.

Top module: `phased_maj_adder`

## Requirements
- R1: While rst_ni is low and after its release, until the first wave reaches the last level, sum_o, cout_o and out_valid_o are 0.
- R2: phase_en_i carries at most one set bit. Bit p enables every gate level k with k mod 3 = p, and a level holds its value whenever its bit is clear. The outputs come from level 3+ceil(log2(W+1)), which is level 8 and phase bit 2 for W=16, and they change only on an edge where that bit is set.
- R3: a_i, b_i, cin_i and in_valid_i are sampled only on an edge where phase_en_i[0] is set. Changing them on any other edge has no effect on the result of the wave already captured.
- R4: {cout_o, sum_o} equals a_i + b_i + cin_i as an unsigned (W+1)-bit sum. It appears on the 8th enabled edge after the capture edge (W=16), and it holds until the next phase-2 edge.
- R5: out_valid_o equals the in_valid_i captured with the same wave. A wave captured with in_valid_i = 0 emerges with out_valid_o = 0.
- R6: Operand pairs presented on consecutive phase-0 edges (one per three-phase rotation) all emerge correct and in order, with no gaps.
- R7: A cycle with phase_en_i = 0 advances no level. A pipeline frozen for any number of cycles resumes without loss or corruption when rotation restarts.
- R8: Carry runs through the full width: 0xFFFF + 0x0000 + 1 gives sum 0x0000 with carry 1, and 0xFFFF + 0xFFFF + 1 gives 0xFFFF with carry 1.
- R9: Nonzero phase_en_i values follow the order 3'b001, 3'b010, 3'b100, 3'b001 ..., and the first one after reset is 3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Edge reference for all stored levels |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_en_i | input | 3 | One-hot excitation phase enables, bit p drives levels k with k mod 3 = p |
| in_valid_i | input | 1 | Marks the operand wave captured at level 0 as valid |
| a_i | input | W | Operand A |
| b_i | input | W | Operand B |
| cin_i | input | 1 | Carry-in |
| sum_o | output | W | Sum from the last level |
| cout_o | output | 1 | Carry-out from the last level |
| out_valid_o | output | 1 | Valid bit that travelled with the emerging wave |

## Verification
The checker assumes that the phase enables are one-hot or zero and that they rotate strictly 0→1→2 from phase 0 after reset. Its reference model of the latency counts only cycles with a phase enabled, so it depends on that rotation. The bench drives phase_en_i from its own rotation counter, which is held at zero during reset and during deliberate freezes. Operands change only at falling edges. Each wave is presented on the phase-0 cycle, and the operand inputs are scrambled on the following cycle to show that level 0 ignores them.

// File: rtl/phased_adder_pkg.sv
package phased_adder_pkg;

  localparam int PHASES = 3;

  typedef enum logic [1:0] {
    FN_BUF = 2'd0,
    FN_AND = 2'd1,
    FN_OR  = 2'd2,
    FN_MAJ = 2'd3
  } gate_fn_e;

endpackage

// File: rtl/clocked_gate.sv
module clocked_gate
  import phased_adder_pkg::*;
#(
  parameter gate_fn_e   FN  = FN_BUF,
  parameter logic [2:0] INV = 3'b000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [2:0] in_i,
  output logic       out_o
);

  logic [2:0] x;
  logic       f;

  assign x = in_i ^ INV;

  always_comb begin
    case (FN)
      FN_AND:  f = x[0] & x[1];
      FN_OR:   f = x[0] | x[1];
      FN_MAJ:  f = (x[0] & x[1]) | (x[0] & x[2]) | (x[1] & x[2]);
      default: f = x[0];
    endcase
  end

  // storage written only during the assigned phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   out_o <= 1'b0;
    else if (en_i) out_o <= f;
  end

endmodule

// File: rtl/gate_row.sv
module gate_row
  import phased_adder_pkg::*;
#(
  parameter int         N   = 16,
  parameter gate_fn_e   FN  = FN_BUF,
  parameter logic [2:0] INV = 3'b000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic [N-1:0] c_i,
  output logic [N-1:0] y_o
);

  for (genvar j = 0; j < N; j++) begin : g_bit
    clocked_gate #(.FN(FN), .INV(INV)) u_gate (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .in_i  ({c_i[j], b_i[j], a_i[j]}),
      .out_o (y_o[j])
    );
  end

endmodule

// File: rtl/prefix_step.sv
module prefix_step
  import phased_adder_pkg::*;
#(
  parameter int N    = 17,
  parameter int DIST = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] t_i,
  output logic [N-1:0] g_o,
  output logic [N-1:0] t_o
);

  for (genvar j = 0; j < N; j++) begin : g_pos
    if (j >= DIST) begin : g_comb
      // generate <= transmit lets one majority cell do g_hi | t_hi & x_lo
      clocked_gate #(.FN(FN_MAJ)) u_g (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
        .in_i ({g_i[j-DIST], t_i[j], g_i[j]}),
        .out_o(g_o[j])
      );
      clocked_gate #(.FN(FN_MAJ)) u_t (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
        .in_i ({t_i[j-DIST], t_i[j], g_i[j]}),
        .out_o(t_o[j])
      );
    end else begin : g_pass
      clocked_gate #(.FN(FN_BUF)) u_g (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
        .in_i ({2'b00, g_i[j]}),
        .out_o(g_o[j])
      );
      clocked_gate #(.FN(FN_BUF)) u_t (
        .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
        .in_i ({2'b00, t_i[j]}),
        .out_o(t_o[j])
      );
    end
  end

endmodule

// File: rtl/phased_maj_adder.sv
module phased_maj_adder
  import phased_adder_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [2:0]   phase_en_i,
  input  logic         in_valid_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         out_valid_o
);

  localparam int N    = W + 1;
  localparam int S    = $clog2(N);
  localparam int LAST = 3 + S;

  logic [W-1:0] zw;
  assign zw = '0;

  // level 0: input splitters
  logic [W-1:0] a_l0, b_l0;
  logic         cin_l0;
  logic         v_q [LAST+1];

  gate_row #(.N(W), .FN(FN_BUF)) u_a_l0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[0]),
    .a_i(a_i), .b_i(zw), .c_i(zw), .y_o(a_l0)
  );
  gate_row #(.N(W), .FN(FN_BUF)) u_b_l0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[0]),
    .a_i(b_i), .b_i(zw), .c_i(zw), .y_o(b_l0)
  );
  clocked_gate #(.FN(FN_BUF)) u_cin_l0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[0]),
    .in_i({2'b00, cin_i}), .out_o(cin_l0)
  );
  clocked_gate #(.FN(FN_BUF)) u_v_l0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[0]),
    .in_i({2'b00, in_valid_i}), .out_o(v_q[0])
  );

  // valid travels through a buffer at every level
  for (genvar k = 1; k <= LAST; k++) begin : g_vld
    clocked_gate #(.FN(FN_BUF)) u_v (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[k % PHASES]),
      .in_i({2'b00, v_q[k-1]}), .out_o(v_q[k])
    );
  end

  // level 1: per-bit generate / transmit, carry-in as position 0
  logic [W-1:0] g_l1, t_l1;
  logic         cg_l1, ct_l1;

  gate_row #(.N(W), .FN(FN_AND)) u_g_l1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[1]),
    .a_i(a_l0), .b_i(b_l0), .c_i(zw), .y_o(g_l1)
  );
  gate_row #(.N(W), .FN(FN_OR)) u_t_l1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[1]),
    .a_i(a_l0), .b_i(b_l0), .c_i(zw), .y_o(t_l1)
  );
  clocked_gate #(.FN(FN_BUF)) u_cg_l1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[1]),
    .in_i({2'b00, cin_l0}), .out_o(cg_l1)
  );
  clocked_gate #(.FN(FN_BUF)) u_ct_l1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[1]),
    .in_i({2'b00, cin_l0}), .out_o(ct_l1)
  );

  // levels 2 .. 1+S: parallel-prefix lookahead
  logic [N-1:0] g_q [S+1];
  logic [N-1:0] t_q [S+1];

  assign g_q[0] = {g_l1, cg_l1};
  assign t_q[0] = {t_l1, ct_l1};

  for (genvar k = 0; k < S; k++) begin : g_pfx
    prefix_step #(.N(N), .DIST(1 << k)) u_step (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (phase_en_i[(2 + k) % PHASES]),
      .g_i   (g_q[k]),
      .t_i   (t_q[k]),
      .g_o   (g_q[k+1]),
      .t_o   (t_q[k+1])
    );
  end

  // half-sum at level 2 (t & ~g), then balancing buffers up to level 1+S
  logic [W-1:0] h_q [S];

  gate_row #(.N(W), .FN(FN_AND), .INV(3'b010)) u_h_l2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[2]),
    .a_i(t_l1), .b_i(g_l1), .c_i(zw), .y_o(h_q[0])
  );

  for (genvar k = 1; k < S; k++) begin : g_hbuf
    gate_row #(.N(W), .FN(FN_BUF)) u_hb (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[(2 + k) % PHASES]),
      .a_i(h_q[k-1]), .b_i(zw), .c_i(zw), .y_o(h_q[k])
    );
  end

  // level 2+S: two product terms of h xor carry
  logic [W-1:0] carry_in, p_hc, p_ch;
  logic         co_pre;

  assign carry_in = g_q[S][W-1:0];

  gate_row #(.N(W), .FN(FN_AND), .INV(3'b010)) u_p_hc (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[(2 + S) % PHASES]),
    .a_i(h_q[S-1]), .b_i(carry_in), .c_i(zw), .y_o(p_hc)
  );
  gate_row #(.N(W), .FN(FN_AND), .INV(3'b001)) u_p_ch (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[(2 + S) % PHASES]),
    .a_i(h_q[S-1]), .b_i(carry_in), .c_i(zw), .y_o(p_ch)
  );
  clocked_gate #(.FN(FN_BUF)) u_co_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[(2 + S) % PHASES]),
    .in_i({2'b00, g_q[S][W]}), .out_o(co_pre)
  );

  // last level: sum and carry-out
  gate_row #(.N(W), .FN(FN_OR)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[LAST % PHASES]),
    .a_i(p_hc), .b_i(p_ch), .c_i(zw), .y_o(sum_o)
  );
  clocked_gate #(.FN(FN_BUF)) u_cout (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(phase_en_i[LAST % PHASES]),
    .in_i({2'b00, co_pre}), .out_o(cout_o)
  );

  assign out_valid_o = v_q[LAST];

endmodule

// File: rtl/phased_maj_adder_chk.sv
module phased_maj_adder_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [2:0]   phase_en_i,
  input logic         in_valid_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         cin_i,
  input logic [W-1:0] sum_o,
  input logic         cout_o,
  input logic         out_valid_o
);

  localparam int S      = $clog2(W + 1);
  localparam int LAT    = 3 + S;
  localparam int OUT_PH = LAT % 3;

  logic [2:0] last_en;
  logic       sh_c [LAT+1];
  logic       sh_v [LAT+1];
  logic [W:0] sh_x [LAT+1];

  // shadow of wave positions, advancing once per enabled phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_en <= 3'b100;
      for (int k = 0; k <= LAT; k++) begin
        sh_c[k] <= 1'b0;
        sh_v[k] <= 1'b0;
        sh_x[k] <= '0;
      end
    end else if (phase_en_i != 3'b000) begin
      last_en <= phase_en_i;
      sh_c[0] <= phase_en_i[0];
      sh_v[0] <= phase_en_i[0] & in_valid_i;
      sh_x[0] <= {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      for (int k = 1; k <= LAT; k++) begin
        sh_c[k] <= sh_c[k-1];
        sh_v[k] <= sh_v[k-1];
        sh_x[k] <= sh_x[k-1];
      end
    end
  end

  assert_phase_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_en_i));

  assert_sum_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_en_i[OUT_PH] |=> $stable({cout_o, sum_o}));

  assert_valid_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_en_i[OUT_PH] |=> $stable(out_valid_o));

  assert_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_en_i == 3'b000) |=> $stable({out_valid_o, cout_o, sum_o}));

  assert_rotation_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_en_i != 3'b000) |-> (phase_en_i == {last_en[1:0], last_en[2]}));

  assert_valid_track_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_c[LAT] |-> (out_valid_o == sh_v[LAT]));

  assert_sum_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_c[LAT] && sh_v[LAT]) |-> ({cout_o, sum_o} == sh_x[LAT]));

endmodule

bind phased_maj_adder phased_maj_adder_chk #(.W(W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_en_i (phase_en_i),
  .in_valid_i (in_valid_i),
  .a_i        (a_i),
  .b_i        (b_i),
  .cin_i      (cin_i),
  .sum_o      (sum_o),
  .cout_o     (cout_o),
  .out_valid_o(out_valid_o)
);

// File: tb/phased_maj_adder_tb_top.sv
`timescale 1ns/1ps
module phased_maj_adder_tb_top;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   phase_en = 3'b000;
  logic         in_valid = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout, out_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  bit stall = 1'b0;
  int ph = 0;

  logic [W-1:0] wa [16];
  logic [W-1:0] wb [16];
  logic         wc [16];
  logic         wv [16];

  always #2.5 clk = ~clk;

  phased_maj_adder #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_en_i(phase_en), .in_valid_i(in_valid),
    .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout), .out_valid_o(out_valid)
  );

  // phase rotation driver, held off during reset and freezes
  always @(negedge clk) begin
    if (!rst_n) begin
      phase_en <= 3'b000;
      ph <= 0;
    end else if (stall) begin
      phase_en <= 3'b000;
    end else begin
      phase_en <= 3'b001 << ph;
      ph <= (ph + 1) % 3;
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sync_phase0();
    do begin
      @(negedge clk);
      #1;
    end while (phase_en != 3'b001);
  endtask

  // one wave per rotation; wave i-3's result is visible when wave i is presented
  task automatic run_waves(int n, string req);
    for (int i = 0; i < n + 3; i++) begin
      sync_phase0();
      if (i >= 3) begin
        chk({req, " R5 valid"}, 64'(out_valid), 64'(wv[i-3]));
        if (wv[i-3])
          chk({req, " R4 sum"}, 64'({cout, sum}),
              64'({1'b0, wa[i-3]} + {1'b0, wb[i-3]} + 17'(wc[i-3])));
      end else begin
        chk({req, " R5 bubble"}, 64'(out_valid), 64'(0));
      end
      if (i < n) begin
        a = wa[i]; b = wb[i]; cin = wc[i]; in_valid = wv[i];
      end else begin
        a = W'($urandom); b = W'($urandom); cin = 1'b1; in_valid = 1'b0;
      end
      @(negedge clk);
      #1;
      // scramble off-phase: R3
      a = ~a; b = b ^ 16'h5a5a; cin = ~cin; in_valid = ~in_valid;
    end
    in_valid = 1'b0;
  endtask

  task automatic test_reset();
    chk("R1 sum", 64'(sum), 64'(0));
    chk("R1 cout", 64'(cout), 64'(0));
    chk("R1 valid", 64'(out_valid), 64'(0));
  endtask

  task automatic test_corners();
    wa[0] = 16'hffff; wb[0] = 16'h0000; wc[0] = 1'b1; wv[0] = 1'b1;
    wa[1] = 16'hffff; wb[1] = 16'hffff; wc[1] = 1'b1; wv[1] = 1'b1;
    wa[2] = 16'h0000; wb[2] = 16'h0000; wc[2] = 1'b0; wv[2] = 1'b1;
    wa[3] = 16'h8000; wb[3] = 16'h8000; wc[3] = 1'b0; wv[3] = 1'b1;
    wa[4] = 16'h5555; wb[4] = 16'haaaa; wc[4] = 1'b1; wv[4] = 1'b1;
    wa[5] = 16'h0001; wb[5] = 16'hffff; wc[5] = 1'b0; wv[5] = 1'b1;
    wa[6] = 16'h7fff; wb[6] = 16'h0000; wc[6] = 1'b1; wv[6] = 1'b1;
    run_waves(7, "R8 corners");
  endtask

  task automatic test_stream();
    for (int i = 0; i < 16; i++) begin
      wa[i] = W'($urandom); wb[i] = W'($urandom);
      wc[i] = 1'($urandom); wv[i] = (i % 5 != 3);
    end
    run_waves(16, "R6 stream");
  endtask

  task automatic test_freeze();
    logic [W:0] exp;
    sync_phase0();
    a = 16'hbeef; b = 16'h4321; cin = 1'b1; in_valid = 1'b1;
    exp = 17'h0beef + 17'h04321 + 17'd1;
    for (int i = 0; i < 3; i++) begin
      sync_phase0();
      a = 16'h1111; b = 16'h2222; cin = 1'b0; in_valid = 1'b0;
    end
    chk("R7 before freeze", 64'({out_valid, cout, sum}), 64'({1'b1, exp}));
    stall = 1'b1;
    repeat (7) @(negedge clk);
    #1;
    chk("R7 phases off", 64'(phase_en), 64'(0));
    a = 16'hffff; b = 16'hffff; cin = 1'b1; in_valid = 1'b1;
    chk("R7 frozen sum", 64'({out_valid, cout, sum}), 64'({1'b1, exp}));
    in_valid = 1'b0;
    stall = 1'b0;
    run_waves(0, "R7 resume");
    wa[0] = 16'h1234; wb[0] = 16'hedcb; wc[0] = 1'b1; wv[0] = 1'b1;
    run_waves(1, "R7 after resume");
  endtask

  task automatic test_hold();
    // R2: result holds over the two non-output phases
    logic [W:0] exp;
    wa[0] = 16'hc0de; wb[0] = 16'h0f0f; wc[0] = 1'b0; wv[0] = 1'b1;
    exp = 17'h0c0de + 17'h00f0f;
    sync_phase0();
    a = wa[0]; b = wb[0]; cin = 1'b0; in_valid = 1'b1;
    @(negedge clk); #1;
    in_valid = 1'b0;
    repeat (8) @(negedge clk);
    #1;
    chk("R2 emerge", 64'({out_valid, cout, sum}), 64'({1'b1, exp}));
    @(negedge clk); #1;
    chk("R2 hold1", 64'({out_valid, cout, sum}), 64'({1'b1, exp}));
    @(negedge clk); #1;
    chk("R2 hold2", 64'({out_valid, cout, sum}), 64'({1'b1, exp}));
    @(negedge clk); #1;
    chk("R2 next", 64'(out_valid), 64'(0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    test_reset();
    test_corners();
    test_stream();
    test_hold();
    test_freeze();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule